// File: doc/BRIEF.md
# Speculative Cache Termination Controller

This block sits between a 32-bit processor bus and a zero-wait-state external cache. It ends read bus cycles early with a synchronous termination strobe before the result of the cache lookup is known. When a cachable read that was ended this way turns out to miss, the block drives bus error and halt low together. The processor takes that pair as a request to retry the cycle.

A single status flip-flop decides whether the next bus cycle may be ended early. It is loaded at the end of each bus cycle, which is the first clock edge that sees address strobe negated. It is cleared when the cycle asserted cache-inhibit-out, or when the cycle was a cachable read that missed. For slower caches, a parameter holds off the termination strobe for a chosen number of clock periods after address strobe asserts.

Top module: `spec_term_ctrl`

## Requirements
- R1: After reset, sterm_n, berr_n and halt_n are high and the status flip-flop is clear. The first read cycle after reset is therefore not ended early, even if it hits.
- R2: sterm_n is low only while as_n is low and rw is 1 (1 = read, 0 = write), with the status flip-flop set.
- R3: While ci_out_n is low (0 = cache inhibited), sterm_n stays high. The bus cycle that follows a cycle with ci_out_n low is not ended early either.
- R4: A cachable read that ends with no cache_hit seen blocks early termination of the next cycle. A cachable read has ci_out_n = 1 and fc != 3'b111. A read miss with fc = 3'b111 does not block it.
- R5: A cycle with fc = 3'b111 is never ended early.
- R6: At a rising clock edge where sterm_n is low and cache_hit is 0, berr_n and halt_n both go low after that edge.
- R7: berr_n and halt_n return high after the first rising edge at which as_n is high.
- R8: A cycle that was not ended early, or that had cache_hit at 1 while it was being ended early, never drives berr_n or halt_n low.
- R9: With WAIT_STATES = N, sterm_n cannot go low until N rising edges have passed with as_n low in the current cycle. With N = 0 it can go low in the same clock period in which as_n falls.
- R10: A write cycle with no cache hit does not block early termination of the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Function code; 3'b111 is CPU space |
| ci_out_n | input | 1 | Cache inhibit out, active low |
| cache_hit | input | 1 | Cache hit flag, active high |
| sterm_n | output | 1 | Synchronous termination, active low |
| berr_n | output | 1 | Bus error, active low |
| halt_n | output | 1 | Halt, active low |

## Verification
The bench builds two instances that share the same inputs. One has WAIT_STATES = 0 and the other has WAIT_STATES = 2. The zero-wait instance covers same-period termination and every rule on the status flip-flop through the vector table. The two-wait instance stays silent during the short table cycles. It is also driven through a long miss cycle, which shows that both the delayed strobe and the retry that follows it move by exactly two clock edges. A reset applied in the middle of the run confirms that the first cycle after reset is suppressed.

// File: rtl/spec_term_ctrl.sv
module spec_term_ctrl #(
  parameter int WAIT_STATES = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       as_n,
  input  logic       rw,
  input  logic [2:0] fc,
  input  logic       ci_out_n,
  input  logic       cache_hit,
  output logic       sterm_n,
  output logic       berr_n,
  output logic       halt_n
);
  localparam logic [2:0] CPU_SPACE = 3'b111;

  logic as_q, en_q, retry_q, ws_ok;
  logic cyc_ci, cyc_hit, cyc_crd;

  wire cyc_end   = as_n && !as_q;
  wire en_next   = !cyc_ci && !(cyc_crd && !cyc_hit);
  wire cachable  = ci_out_n && (fc != CPU_SPACE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      as_q <= 1'b1;
      en_q <= 1'b0;
    end else begin
      as_q <= as_n;
      if (cyc_end) en_q <= en_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || as_n) begin
      cyc_ci  <= 1'b0;
      cyc_hit <= 1'b0;
      cyc_crd <= 1'b0;
    end else begin
      cyc_ci  <= cyc_ci  | !ci_out_n;
      cyc_hit <= cyc_hit | cache_hit;
      cyc_crd <= cyc_crd | (rw && cachable);
    end
  end

  generate
    if (WAIT_STATES == 0) begin : g_nowait
      assign ws_ok = 1'b1;
    end else begin : g_wait
      localparam int CW = $clog2(WAIT_STATES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(WAIT_STATES);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || as_n) cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
      end
      assign ws_ok = (cnt == LIMIT);
    end
  endgenerate

  assign sterm_n = !(!as_n && rw && en_q && cachable && ws_ok);

  always_ff @(posedge clk) begin
    if (!rst_n || as_n) retry_q <= 1'b0;
    else retry_q <= retry_q | (!sterm_n && !cache_hit);
  end

  assign berr_n = !retry_q;
  assign halt_n = !retry_q;

  assert_retry_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(berr_n) |-> $past(!sterm_n && !cache_hit));
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (berr_n && halt_n));
  assert_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sterm_n |-> (!as_n && rw));
  assert_no_cpu_inh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sterm_n |-> (fc != CPU_SPACE && ci_out_n));
  assert_hit_no_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || berr_n) && (sterm_n || cache_hit) |=> berr_n);
endmodule

// File: tb/spec_term_ctrl_bench.sv
module spec_term_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int NV = 14;
  // {rw, fc[2:0], ci_asserted, hit, exp_sterm, exp_retry}
  localparam logic [7:0] VEC [NV] = '{
    8'b1_101_0_1_0_0,  // R1 first read after reset not early
    8'b1_101_0_1_1_0,  // R2 early hit
    8'b1_101_0_0_1_1,  // R6 early miss -> retry
    8'b1_101_0_1_0_0,  // R4 suppressed after miss
    8'b1_111_0_0_0_0,  // R5 cpu space
    8'b1_101_0_1_1_0,  // R4 cpu-space miss does not suppress
    8'b1_101_1_1_0_0,  // R3 inhibited
    8'b1_101_0_1_0_0,  // R3 suppressed after inhibit
    8'b0_101_0_0_0_0,  // R2 write not early
    8'b1_001_0_1_1_0,  // R10 write miss does not suppress
    8'b1_101_1_0_0_0,  // R3 inhibit miss
    8'b1_010_0_0_0_0,  // R8 not early, miss, no retry
    8'b1_010_0_1_0_0,  // R4 suppressed after miss
    8'b1_110_0_0_1_1   // R6 early miss again
  };

  logic clk = 0, rst_n = 0, as_n = 1, rw = 1, ci_out_n = 1, cache_hit = 0;
  logic [2:0] fc = 3'b101;
  logic st0, be0, ha0, st2, be2, ha2;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  spec_term_ctrl #(.WAIT_STATES(0)) u_spec_term_ctrl (
    .clk, .rst_n, .as_n, .rw, .fc, .ci_out_n, .cache_hit,
    .sterm_n(st0), .berr_n(be0), .halt_n(ha0));
  spec_term_ctrl #(.WAIT_STATES(2)) u_spec_term_ctrl_w2 (
    .clk, .rst_n, .as_n, .rw, .fc, .ci_out_n, .cache_hit,
    .sterm_n(st2), .berr_n(be2), .halt_n(ha2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input logic a, input logic e, input string tag);
    chk(a === e, tag, int'(a), int'(e));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic cycle(input logic [7:0] v, input string tag);
    @(negedge clk);
    as_n = 0; rw = v[7]; fc = v[6:4]; ci_out_n = !v[3]; cache_hit = v[2];
    #1;
    eq(st0, !v[1], {tag, " sterm"});
    eq(st2, 1'b1, "R9 waited sterm short cycle");
    @(posedge clk); #1;
    eq(be0, !v[0], {tag, " berr"});
    eq(ha0, !v[0], {tag, " halt R6"});
    eq(be2, 1'b1, "R8 waited no retry");
    @(negedge clk);
    as_n = 1; cache_hit = 0;
    #1 eq(st0, 1'b1, "R2 sterm idle");
    @(posedge clk); #1;
    eq(be0, 1'b1, "R7 berr released");
    eq(ha0, 1'b1, "R7 halt released");
  endtask

  initial begin
    #(PERIOD * 5000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    eq(st0, 1'b1, "R1 reset sterm");
    eq(be0, 1'b1, "R1 reset berr");
    eq(ha0, 1'b1, "R1 reset halt");
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) cycle(VEC[i], $sformatf("vec%0d", i));

    cycle(8'b1_101_0_1_0_0, "R4 primer");
    @(negedge clk);
    as_n = 0; rw = 1; fc = 3'b101; ci_out_n = 1; cache_hit = 0;
    #1;
    eq(st0, 1'b0, "R9 N=0 same period");
    eq(st2, 1'b1, "R9 N=2 held 0 edges");
    @(posedge clk); #1;
    eq(be0, 1'b0, "R6 N=0 retry");
    eq(st2, 1'b1, "R9 N=2 held 1 edge");
    eq(be2, 1'b1, "R8 N=2 no retry yet");
    @(posedge clk); #1;
    eq(st2, 1'b0, "R9 N=2 after 2 edges");
    eq(be2, 1'b1, "R6 N=2 retry not yet");
    @(posedge clk); #1;
    eq(be2, 1'b0, "R6 N=2 berr");
    eq(ha2, 1'b0, "R6 N=2 halt");
    @(negedge clk) as_n = 1;
    @(posedge clk); #1;
    eq(be2, 1'b1, "R7 N=2 released");
    eq(be0, 1'b1, "R7 N=0 released");

    cycle(8'b1_101_0_1_0_0, "R4 after long miss");
    cycle(8'b1_101_0_1_1_0, "R2 enabled again");
    @(negedge clk) rst_n = 0;
    @(posedge clk); #1;
    eq(st0, 1'b1, "R1 mid reset sterm");
    @(negedge clk) rst_n = 1;
    cycle(8'b1_101_0_1_0_0, "R1 first after reset");

    finish_run();
  end
endmodule